// File: doc/BRIEF.md
# ADC Auto-Sequencer Engine

This block walks a programmed list of one to eight conversion slots on a single shared converter. A run begins on a selected edge of one of fourteen PWM outputs or one of four timer outputs, or on a direct start request from the converter arbiter. Each slot can send a 7-bit code to an external analog multiplexer. The code goes out either when the slot begins or once the converter reports that sample-and-hold has finished. The slot then waits a programmed number of ADC input-clock ticks, presents its input select and pulses a conversion start. When the converter reports done, the result is written into the result field that belongs to that slot.

Each slot's configuration is a 14-bit word: input select in bits [2:0], delay code in bits [4:3], send mode in bits [6:5] and external-mux code in bits [13:7]. Slot k occupies `slot_cfg_i[k*14 +: 14]`. Result k appears on `res_o[k*RES_W +: RES_W]`. The ADC input clock is an enable derived from the fabric clock. It runs freely from reset and is not phase-aligned to a run.

Top module: `adc_autoseq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `conv_start_o` and `emux_send_o` are 0 and every result field is 0.
- R2: With `trig_src_i`=0 the trigger is `pwm_i[pwm_sel_i]` (index 0..13, larger values select nothing). With `trig_src_i`=1 it is `tmr_i[tmr_sel_i]`. Edges on unselected lines start nothing.
- R3: With `trig_rise_i`=1 a low-to-high edge of the selected line launches a run. With `trig_rise_i`=0 a high-to-low edge does. The opposite edge starts nothing.
- R4: A `start_i` pulse launches a run when the block is enabled and idle, whatever the trigger lines do.
- R5: While `en_i` is 0, neither `start_i` nor trigger edges launch a run.
- R6: A depth code n on `depth_i` runs slots 0..n in order. Each slot gives exactly one `conv_start_o` pulse, and during that pulse `conv_sel_o` carries that slot's input select unchanged (0 external mux, 2..5 analog pins, 7 analog ground).
- R7: Send mode 0 sends nothing. Send mode 1 pulses `emux_send_o` for one cycle with the slot's code when the slot begins, and the delay starts only after `emux_done_i`. Send mode 2 pulses `emux_send_o` the cycle after `conv_sh_i`, and the slot does not complete until `emux_done_i` has also arrived.
- R8: Delay codes 0, 1, 2, 3 insert 0, 4, 8, 16 input-clock ticks before the conversion start. With code 0, `conv_start_o` rises in the first cycle of the slot.
- R9: An input-clock tick occurs once every `clk_div_i`+1 fabric cycles.
- R10: On `conv_done_i` the value on `conv_data_i` is stored in the current slot's result field and is held there until that slot converts again.
- R11: `busy_o` is high from the cycle after launch until the run completes. `done_o` is a one-cycle pulse in the cycle where `busy_o` falls.
- R12: Start requests and trigger edges that arrive while a run is active are ignored, so each launch yields exactly one `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| start_i | input | 1 | Direct launch request from the arbiter |
| trig_src_i | input | 1 | Trigger class: 0 PWM, 1 timer |
| trig_rise_i | input | 1 | Edge polarity: 1 rising, 0 falling |
| pwm_sel_i | input | 4 | PWM line index |
| tmr_sel_i | input | 2 | Timer line index |
| pwm_i | input | 14 | PWM trigger lines |
| tmr_i | input | 4 | Timer trigger lines |
| depth_i | input | 3 | Last slot index of a run |
| clk_div_i | input | 3 | Input-clock divide code (factor = code+1) |
| slot_cfg_i | input | 112 | Packed per-slot configuration words |
| conv_start_o | output | 1 | Conversion start pulse |
| conv_sel_o | output | 3 | Converter input select for the current slot |
| conv_sh_i | input | 1 | Converter sample-and-hold finished pulse |
| conv_done_i | input | 1 | Converter result valid pulse |
| conv_data_i | input | 9 | Converter result |
| emux_send_o | output | 1 | External-mux send request pulse |
| emux_code_o | output | 7 | Code for the external mux |
| emux_done_i | input | 1 | External-mux transfer finished pulse |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished pulse |
| res_o | output | 72 | Packed per-slot results |

## Verification
The embedded properties check, on every cycle, the status relations: `done_o` coincides with the fall of `busy_o` and never lasts two cycles; a conversion start never occurs while idle or together with a mux send; an idle, disabled engine stays idle; an expiring delay count produces a start; and input-clock ticks are spaced by the divide code. Trigger selection, edge polarity, slot ordering, delay length, the two send timings and the results held per slot depend on stimulus history. Only the bench scenarios can show these, comparing the ports against a behavioural model on every clock and against measured gaps and counts.

// File: rtl/aseq_pkg.sv
package aseq_pkg;

  localparam int CODE_W = 7;
  localparam int SEL_W  = 3;
  localparam int DCNT_W = 5;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [1:0]        send;
    logic [1:0]        dly;
    logic [SEL_W-1:0]  sel;
  } slot_cfg_t;

  localparam int SLOT_W = $bits(slot_cfg_t);

  localparam logic [1:0] SEND_NONE = 2'd0;
  localparam logic [1:0] SEND_PRE  = 2'd1;
  localparam logic [1:0] SEND_POST = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_REQ, ST_PRE_WAIT, ST_DLY, ST_CONV_REQ, ST_CONV_WAIT, ST_POST_WAIT
  } seq_st_e;

  function automatic logic [DCNT_W-1:0] dly_ticks(input logic [1:0] c);
    case (c)
      2'd0:    dly_ticks = DCNT_W'(0);
      2'd1:    dly_ticks = DCNT_W'(4);
      2'd2:    dly_ticks = DCNT_W'(8);
      default: dly_ticks = DCNT_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/aseq_trig.sv
module aseq_trig #(
  parameter int NPWM   = 14,
  parameter int NTMR   = 4,
  parameter int PSEL_W = 4,
  parameter int TSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  input  logic              rise_i,
  input  logic [PSEL_W-1:0] pwm_sel_i,
  input  logic [TSEL_W-1:0] tmr_sel_i,
  input  logic [NPWM-1:0]   pwm_i,
  input  logic [NTMR-1:0]   tmr_i,
  output logic              evt_o
);

  logic sig, prev_q;

  always_comb begin
    sig = 1'b0;
    if (src_i) begin
      for (int i = 0; i < NTMR; i++)
        if (tmr_sel_i == TSEL_W'(i)) sig = tmr_i[i];
    end else begin
      for (int i = 0; i < NPWM; i++)
        if (pwm_sel_i == PSEL_W'(i)) sig = pwm_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig;

  assign evt_o = rise_i ? (sig & ~prev_q) : (~sig & prev_q);

endmodule

// File: rtl/aseq_tick.sv
module aseq_tick #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;

  // R9
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/aseq_ctrl.sv
module aseq_ctrl import aseq_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [IDX_W-1:0]  depth_i,
  input  slot_cfg_t         cfg_i [NSLOT],
  input  logic              tick_i,
  input  logic              conv_sh_i,
  input  logic              conv_done_i,
  input  logic              emux_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              conv_start_o,
  output logic [SEL_W-1:0]  conv_sel_o,
  output logic              emux_send_o,
  output logic [CODE_W-1:0] emux_code_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o
);

  seq_st_e           st_q, st_d;
  logic [IDX_W-1:0]  cur_q, cur_d, begin_idx;
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic              pend_q, pend_d, post_req_q, post_req_d, done_q, done_d;
  logic              begin_slot, end_slot;
  slot_cfg_t         cur_cfg, nxt_cfg;

  assign cur_cfg = cfg_i[cur_q];
  assign nxt_cfg = cfg_i[begin_idx];

  always_comb begin
    st_d       = st_q;
    cur_d      = cur_q;
    dcnt_d     = dcnt_q;
    pend_d     = pend_q;
    post_req_d = 1'b0;
    done_d     = 1'b0;
    wr_en_o    = 1'b0;
    begin_slot = 1'b0;
    end_slot   = 1'b0;
    begin_idx  = cur_q;

    case (st_q)
      ST_IDLE: if (launch_i) begin
        begin_slot = 1'b1;
        begin_idx  = '0;
      end
      ST_PRE_REQ: st_d = ST_PRE_WAIT;
      ST_PRE_WAIT: if (emux_done_i) begin
        if (cur_cfg.dly == 2'd0) st_d = ST_CONV_REQ;
        else begin
          st_d   = ST_DLY;
          dcnt_d = dly_ticks(cur_cfg.dly);
        end
      end
      ST_DLY: if (tick_i) begin
        dcnt_d = dcnt_q - 1'b1;
        if (dcnt_q == DCNT_W'(1)) st_d = ST_CONV_REQ;
      end
      ST_CONV_REQ: st_d = ST_CONV_WAIT;
      ST_CONV_WAIT: begin
        if (pend_q && emux_done_i) pend_d = 1'b0;
        if (conv_sh_i && cur_cfg.send == SEND_POST) begin
          post_req_d = 1'b1;
          pend_d     = 1'b1;
        end
        if (conv_done_i) begin
          wr_en_o = 1'b1;
          if (pend_d) st_d = ST_POST_WAIT;
          else        end_slot = 1'b1;
        end
      end
      ST_POST_WAIT: if (pend_q && emux_done_i) begin
        pend_d   = 1'b0;
        end_slot = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase

    if (end_slot) begin
      if (cur_q == depth_i) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else begin
        begin_slot = 1'b1;
        begin_idx  = IDX_W'(cur_q + 1'b1);
      end
    end

    if (begin_slot) begin
      cur_d = begin_idx;
      if (nxt_cfg.send == SEND_PRE)  st_d = ST_PRE_REQ;
      else if (nxt_cfg.dly == 2'd0)  st_d = ST_CONV_REQ;
      else begin
        st_d   = ST_DLY;
        dcnt_d = dly_ticks(nxt_cfg.dly);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cur_q      <= '0;
      dcnt_q     <= '0;
      pend_q     <= 1'b0;
      post_req_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      cur_q      <= cur_d;
      dcnt_q     <= dcnt_d;
      pend_q     <= pend_d;
      post_req_q <= post_req_d;
      done_q     <= done_d;
    end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign conv_start_o = (st_q == ST_CONV_REQ);
  assign conv_sel_o   = cur_cfg.sel;
  assign emux_send_o  = (st_q == ST_PRE_REQ) | post_req_q;
  assign emux_code_o  = cur_cfg.code;
  assign wr_idx_o     = cur_q;

  // R11
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R6
  conv_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy_o);
  // R7
  send_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emux_send_o |-> !conv_start_o);
  // R8
  dly_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DLY && tick_i && dcnt_q == DCNT_W'(1)) |=> conv_start_o);

endmodule

// File: rtl/aseq_results.sv
module aseq_results #(
  parameter int NSLOT = 8,
  parameter int RES_W = 9,
  parameter int IDX_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [RES_W-1:0]       data_i,
  output logic [NSLOT*RES_W-1:0] res_o
);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [RES_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                    r_q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(k))      r_q <= data_i;
    assign res_o[k*RES_W +: RES_W] = r_q;
  end

endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq import aseq_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int RES_W = 9,
  parameter int NPWM  = 14,
  parameter int NTMR  = 4,
  parameter int DIV_W = 3,
  localparam int IDX_W  = $clog2(NSLOT),
  localparam int PSEL_W = $clog2(NPWM),
  localparam int TSEL_W = $clog2(NTMR)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    start_i,
  input  logic                    trig_src_i,
  input  logic                    trig_rise_i,
  input  logic [PSEL_W-1:0]       pwm_sel_i,
  input  logic [TSEL_W-1:0]       tmr_sel_i,
  input  logic [NPWM-1:0]         pwm_i,
  input  logic [NTMR-1:0]         tmr_i,
  input  logic [IDX_W-1:0]        depth_i,
  input  logic [DIV_W-1:0]        clk_div_i,
  input  logic [NSLOT*SLOT_W-1:0] slot_cfg_i,
  output logic                    conv_start_o,
  output logic [SEL_W-1:0]        conv_sel_o,
  input  logic                    conv_sh_i,
  input  logic                    conv_done_i,
  input  logic [RES_W-1:0]        conv_data_i,
  output logic                    emux_send_o,
  output logic [CODE_W-1:0]       emux_code_o,
  input  logic                    emux_done_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [NSLOT*RES_W-1:0]  res_o
);

  slot_cfg_t        cfg [NSLOT];
  logic             evt, tick, launch, wr_en;
  logic [IDX_W-1:0] wr_idx;

  for (genvar k = 0; k < NSLOT; k++) begin : g_cfg
    assign cfg[k] = slot_cfg_t'(slot_cfg_i[k*SLOT_W +: SLOT_W]);
  end

  aseq_trig #(.NPWM(NPWM), .NTMR(NTMR), .PSEL_W(PSEL_W), .TSEL_W(TSEL_W)) u_trig (
    .clk_i, .rst_ni,
    .src_i(trig_src_i), .rise_i(trig_rise_i),
    .pwm_sel_i, .tmr_sel_i, .pwm_i, .tmr_i,
    .evt_o(evt)
  );

  aseq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i(clk_div_i), .tick_o(tick)
  );

  assign launch = en_i & (evt | start_i);

  aseq_ctrl #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .launch_i(launch), .depth_i, .cfg_i(cfg), .tick_i(tick),
    .conv_sh_i, .conv_done_i, .emux_done_i,
    .busy_o, .done_o, .conv_start_o, .conv_sel_o,
    .emux_send_o, .emux_code_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx)
  );

  aseq_results #(.NSLOT(NSLOT), .RES_W(RES_W), .IDX_W(IDX_W)) u_res (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .data_i(conv_data_i),
    .res_o
  );

  // R5
  idle_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !en_i) |=> !busy_o);

endmodule

// File: tb/adc_autoseq_tb.sv
module adc_autoseq_tb;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         en_i = 1'b0, start_i = 1'b0, trig_src_i = 1'b0, trig_rise_i = 1'b1;
  logic [3:0]   pwm_sel_i = '0;
  logic [1:0]   tmr_sel_i = '0;
  logic [13:0]  pwm_i = '0;
  logic [3:0]   tmr_i = '0;
  logic [2:0]   depth_i = '0, clk_div_i = '0;
  logic [111:0] slot_cfg_i;
  logic         conv_sh_i = 1'b0, conv_done_i = 1'b0, emux_done_i = 1'b0;
  logic [8:0]   conv_data_i = '0;
  logic         conv_start_o, emux_send_o, busy_o, done_o;
  logic [2:0]   conv_sel_o;
  logic [6:0]   emux_code_o;
  logic [71:0]  res_o;

  logic [6:0] b_code [8];
  logic [1:0] b_send [8];
  logic [1:0] b_dly  [8];
  logic [2:0] b_sel  [8];

  int nchk = 0, nerr = 0, cyc = 0;
  bit chk_on = 1'b0;

  adc_autoseq u_dut (
    .clk_i, .rst_ni, .en_i, .start_i, .trig_src_i, .trig_rise_i,
    .pwm_sel_i, .tmr_sel_i, .pwm_i, .tmr_i, .depth_i, .clk_div_i, .slot_cfg_i,
    .conv_start_o, .conv_sel_o, .conv_sh_i, .conv_done_i, .conv_data_i,
    .emux_send_o, .emux_code_o, .emux_done_i, .busy_o, .done_o, .res_o
  );

  always #5 clk_i = ~clk_i;

  always_comb
    for (int k = 0; k < 8; k++)
      slot_cfg_i[k*14 +: 14] = {b_code[k], b_send[k], b_dly[k], b_sel[k]};

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ticks_of(input logic [1:0] c);
    return (c == 2'd0) ? 0 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 16;
  endfunction

  // ---------------- behavioural reference model ----------------
  int         m_ph, m_slot, m_rem, m_tc;
  bit         m_pend, m_prev, m_done, m_cs, m_es;
  logic [8:0] m_res [8];

  task automatic m_enter();
    if (b_send[m_slot] == 2'd1) begin m_ph = 1; m_es = 1'b1; end
    else if (b_dly[m_slot] == 2'd0) begin m_ph = 3; m_cs = 1'b1; end
    else begin m_ph = 2; m_rem = ticks_of(b_dly[m_slot]); end
  endtask

  task automatic m_after_pre();
    if (b_dly[m_slot] == 2'd0) begin m_ph = 3; m_cs = 1'b1; end
    else begin m_ph = 2; m_rem = ticks_of(b_dly[m_slot]); end
  endtask

  task automatic m_end();
    if (m_slot == int'(depth_i)) begin m_ph = 0; m_done = 1'b1; end
    else begin m_slot++; m_enter(); end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_slot = 0; m_rem = 0; m_tc = 0;
      m_pend = 0; m_prev = 0; m_done = 0; m_cs = 0; m_es = 0;
      for (int k = 0; k < 8; k++) m_res[k] = '0;
    end else begin
      bit tk, sig, evt;
      m_done = 0; m_cs = 0; m_es = 0;
      tk = (m_tc >= int'(clk_div_i));
      m_tc = tk ? 0 : m_tc + 1;
      if (trig_src_i) sig = tmr_i[tmr_sel_i];
      else            sig = (pwm_sel_i < 4'd14) ? pwm_i[pwm_sel_i] : 1'b0;
      evt = trig_rise_i ? (sig && !m_prev) : (!sig && m_prev);
      m_prev = sig;
      case (m_ph)
        0: if (en_i && (evt || start_i)) begin m_slot = 0; m_enter(); end
        1: if (emux_done_i) m_after_pre();
        2: if (tk) begin
             m_rem--;
             if (m_rem == 0) begin m_ph = 3; m_cs = 1'b1; end
           end
        3: begin
             if (m_pend && emux_done_i) m_pend = 0;
             if (conv_sh_i && b_send[m_slot] == 2'd2) begin m_es = 1'b1; m_pend = 1'b1; end
             if (conv_done_i) begin
               m_res[m_slot] = conv_data_i;
               if (m_pend) m_ph = 4; else m_end();
             end
           end
        4: if (m_pend && emux_done_i) begin m_pend = 0; m_end(); end
        default: m_ph = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk_i) begin
    if (rst_ni && chk_on) begin
      chk(busy_o == (m_ph != 0), "R11", "busy_o", busy_o, m_ph != 0);
      chk(done_o == m_done, "R11", "done_o", done_o, m_done);
      chk(conv_start_o == m_cs, "R6", "conv_start_o", conv_start_o, m_cs);
      if (m_cs) chk(conv_sel_o == b_sel[m_slot], "R6", "conv_sel_o", conv_sel_o, b_sel[m_slot]);
      chk(emux_send_o == m_es, "R7", "emux_send_o", emux_send_o, m_es);
      if (m_es) chk(emux_code_o == b_code[m_slot], "R7", "emux_code_o", emux_code_o, b_code[m_slot]);
      for (int k = 0; k < 8; k++)
        chk(res_o[k*9 +: 9] == m_res[k], "R10", $sformatf("res slot %0d", k),
            res_o[k*9 +: 9], m_res[k]);
    end
  end

  // ---------------- converter and external-mux responders ----------------
  int sh_lat = 1, dn_lat = 3, em_lat = 3;
  int sh_cnt = 0, dn_cnt = 0, em_cnt = 0;
  int cnt_cs = 0, cnt_es = 0, cnt_done = 0;
  logic [8:0] data_seq = 9'h03;
  logic [8:0] rec_q [$];

  always @(negedge clk_i) begin
    conv_sh_i = 1'b0; conv_done_i = 1'b0; emux_done_i = 1'b0;
    if (sh_cnt > 0) begin sh_cnt--; if (sh_cnt == 0) conv_sh_i = 1'b1; end
    if (dn_cnt > 0) begin
      dn_cnt--;
      if (dn_cnt == 0) begin
        data_seq = data_seq * 9'd7 + 9'd13;
        conv_data_i = data_seq;
        conv_done_i = 1'b1;
        rec_q.push_back(data_seq);
      end
    end
    if (em_cnt > 0) begin em_cnt--; if (em_cnt == 0) emux_done_i = 1'b1; end
    if (rst_ni) begin
      if (conv_start_o) begin sh_cnt = sh_lat; dn_cnt = dn_lat; cnt_cs++; end
      if (emux_send_o) begin em_cnt = em_lat; cnt_es++; end
      if (done_o) cnt_done++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 3000) begin @(negedge clk_i); n++; end
    chk(done_o == 1'b1, tag, "run completion done_o", done_o, 1);
    chk(busy_o == 1'b0, "R11", "busy_o with done_o", busy_o, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R11", "done_o second cycle", done_o, 0);
  endtask

  task automatic meas_gap(output int g);
    g = 0;
    while (!conv_start_o && g < 300) begin @(negedge clk_i); g++; end
  endtask

  task automatic check_results(input int first, input int nslots, input string tag);
    for (int k = 0; k < nslots; k++)
      chk(res_o[k*9 +: 9] == rec_q[first+k], tag, $sformatf("stored result slot %0d", k),
          res_o[k*9 +: 9], rec_q[first+k]);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    int c0, e0, d0, q0, g;
    for (int k = 0; k < 8; k++) begin
      b_code[k] = 7'(k * 9 + 1); b_send[k] = 2'd0; b_dly[k] = 2'd0; b_sel[k] = 3'(k);
    end
    idle(3);
    rst_ni = 1'b1;
    chk_on = 1'b1;
    @(negedge clk_i);
    // R1
    chk(busy_o == 0 && done_o == 0, "R1", "busy/done after reset", {busy_o, done_o}, 0);
    chk(conv_start_o == 0 && emux_send_o == 0, "R1", "requests after reset",
        {conv_start_o, emux_send_o}, 0);
    chk(res_o == '0, "R1", "results after reset", int'(res_o[31:0]), 0);

    // R4 R6 R10: direct start, four slots, no sends, no delay
    en_i = 1'b1; depth_i = 3'd3; clk_div_i = 3'd0;
    b_sel[0] = 3'd2; b_sel[1] = 3'd3; b_sel[2] = 3'd4; b_sel[3] = 3'd5;
    c0 = cnt_cs; q0 = rec_q.size();
    pulse_start();
    wait_done("R4");
    chk(cnt_cs - c0 == 4, "R6", "conversions for depth 3", cnt_cs - c0, 4);
    check_results(q0, 4, "R10");
    idle(4);

    // R2 R3 R7 R8 R9: PWM line 9 rising edge, send-before on slot 0
    trig_src_i = 1'b0; trig_rise_i = 1'b1; pwm_sel_i = 4'd9; depth_i = 3'd1; clk_div_i = 3'd2;
    b_send[0] = 2'd1; b_code[0] = 7'h55; b_dly[0] = 2'd1; b_sel[0] = 3'd7;
    b_send[1] = 2'd0; b_code[1] = 7'h2a; b_dly[1] = 2'd2; b_sel[1] = 3'd0;
    pwm_i[5] = 1'b1; idle(2); pwm_i[5] = 1'b0; idle(3);
    chk(busy_o == 1'b0, "R2", "unselected PWM line launches", busy_o, 0);
    e0 = cnt_es; c0 = cnt_cs;
    pwm_i[9] = 1'b1; idle(2);
    chk(busy_o == 1'b1, "R3", "rising edge on selected PWM", busy_o, 1);
    wait_done("R2");
    pwm_i[9] = 1'b0;
    chk(cnt_es - e0 == 1, "R7", "send-before pulses", cnt_es - e0, 1);
    chk(cnt_cs - c0 == 2, "R6", "conversions for depth 1", cnt_cs - c0, 2);
    idle(4);
    chk(busy_o == 1'b0, "R3", "falling edge in rising mode", busy_o, 0);

    // R3 R7: timer 2 falling edge, eight slots, mixed sends, sh with done
    trig_src_i = 1'b1; trig_rise_i = 1'b0; tmr_sel_i = 2'd2; depth_i = 3'd7; clk_div_i = 3'd1;
    sh_lat = 2; dn_lat = 2;
    for (int k = 0; k < 8; k++) begin
      b_code[k] = 7'(k * 13 + 5); b_dly[k] = 2'(k % 4); b_sel[k] = 3'(7 - k);
      b_send[k] = (k == 1 || k == 4 || k == 6) ? 2'd2 : (k == 3) ? 2'd1 : 2'd0;
    end
    tmr_i[2] = 1'b1; idle(3);
    chk(busy_o == 1'b0, "R3", "rising edge in falling mode", busy_o, 0);
    e0 = cnt_es; c0 = cnt_cs; q0 = rec_q.size();
    tmr_i[2] = 1'b0; idle(2);
    chk(busy_o == 1'b1, "R3", "falling edge on selected timer", busy_o, 1);
    wait_done("R3");
    chk(cnt_es - e0 == 4, "R7", "mux sends in mixed run", cnt_es - e0, 4);
    chk(cnt_cs - c0 == 8, "R6", "conversions for depth 7", cnt_cs - c0, 8);
    check_results(q0, 8, "R10");
    sh_lat = 1; dn_lat = 3;
    idle(4);

    // R5: disabled engine
    en_i = 1'b0;
    pulse_start();
    tmr_i[2] = 1'b1; idle(2); tmr_i[2] = 1'b0; idle(4);
    chk(busy_o == 1'b0, "R5", "launch while disabled", busy_o, 0);
    en_i = 1'b1;

    // R12 R7: requests during a run, send-after with mux done before conv done
    trig_src_i = 1'b0; trig_rise_i = 1'b1; pwm_sel_i = 4'd0; depth_i = 3'd2; clk_div_i = 3'd0;
    dn_lat = 8;
    for (int k = 0; k < 3; k++) begin b_dly[k] = 2'd3; b_send[k] = 2'd0; end
    b_send[1] = 2'd2;
    d0 = cnt_done; e0 = cnt_es;
    pulse_start();
    idle(5);
    pulse_start();
    pwm_i[0] = 1'b1; idle(3); pwm_i[0] = 1'b0;
    wait_done("R12");
    idle(60);
    chk(cnt_done - d0 == 1, "R12", "done pulses for one launch", cnt_done - d0, 1);
    chk(busy_o == 1'b0, "R12", "busy after ignored requests", busy_o, 0);
    chk(cnt_es - e0 == 1, "R7", "send-after pulses", cnt_es - e0, 1);
    dn_lat = 3;

    // R8: exact delay with divide-by-1
    depth_i = 3'd0; b_send[0] = 2'd0; b_dly[0] = 2'd3; clk_div_i = 3'd0;
    pulse_start(); meas_gap(g);
    chk(g == 16, "R8", "cycles to start, delay code 3", g, 16);
    wait_done("R8"); idle(3);
    b_dly[0] = 2'd0;
    pulse_start(); meas_gap(g);
    chk(g == 0, "R8", "cycles to start, delay code 0", g, 0);
    wait_done("R8"); idle(3);

    // R9: divide-by-4, 4 ticks land between 13 and 16 cycles
    b_dly[0] = 2'd1; clk_div_i = 3'd3;
    pulse_start(); meas_gap(g);
    chk(g >= 13 && g <= 16, "R9", "cycles to start, divide by 4", g, 16);
    wait_done("R9"); idle(3);

    chk_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule